// File: doc/BRIEF.md
# Non-blocking write-through data cache controller

This block sits between a processor and a memory that moves whole lines. It holds a direct-mapped array of lines with a tag and a valid bit per line, and serves one word per processor request. A request is offered on the request inputs and the block answers in the same cycle whether it took it; a refused request must be offered again. Results come back on a response output that carries either a word or nothing in every cycle, and the processor must take whatever appears, because nothing is held for it.

Work is split into a request phase and a response phase one cycle apart. A load hit is marked in a one-cycle hit slot and answered in the following cycle. A load miss sends a line read to memory and is recorded in a small miss queue. A returned line is installed at the recorded index, and the waiting word is answered from it. Stores always write the word through to memory. A store that hits also updates the cached copy, and a store that misses leaves the array untouched, so there are no dirty bits and no eviction traffic. A parameter turns the block into a blocking cache that takes nothing while a miss is outstanding.

Top module: `wt_dcache`

Addresses are word addresses. Offset bits are `[OFF-1:0]`, the index is the next `IDX` bits, and the tag is the rest. With the defaults (4 words per line, 8 lines) the offset is `[1:0]`, the index `[4:2]` and the tag `[15:5]`. Word `w` of a line lies at bits `[32*w+31:32*w]` of `mrsp_line`.

## Requirements
- R1: After reset no line is valid, `rsp_valid`, `mreq_push` and `mrsp_pop` are low, and the first load to any address is treated as a miss.
- R2: A load whose tag matches a valid line is accepted in the cycle it is offered, even when `mreq_full` is high, and pushes nothing to memory. In the next cycle `rsp_valid` is high and `rsp_data` carries the cached word.
- R3: A load that misses is accepted only when `mreq_full` is low and the miss queue has room (default depth 2). In its accept cycle it pushes a line read: `mreq_push`=1, `mreq_store`=0, and `mreq_addr` equal to the request address with the offset bits cleared. In the next cycle `rsp_valid` is low.
- R4: When `mrsp_empty` is low, the miss queue is not empty and no hit or miss slot is active, the block raises `mrsp_pop` and installs the line at the oldest entry's index and tag. In the same cycle it raises `rsp_valid` with the word at that entry's saved offset. Misses complete in the order they were accepted, and every accepted load is answered exactly once.
- R5: The response phase serves the hit slot first, then the miss slot, then a returned line. While a hit or miss slot is active, `mrsp_pop` stays low even if a line is waiting.
- R6: An accepted store pushes `mreq_push`=1, `mreq_store`=1, `mreq_addr`=request address and `mreq_wdata`=store data in its accept cycle. A store is refused when `mreq_full` is high, and a store never raises `rsp_valid`.
- R7: A store that hits replaces the cached word, and a later load hit to that address returns the stored value.
- R8: A store that misses does not allocate a line, so a later load to that line misses and issues a line read.
- R9: A store is refused while the miss queue holds any entry.
- R10: With blocking mode off, load hits are accepted and answered while misses are outstanding.
- R11: With blocking mode on, every request is refused while the miss queue holds any entry.
- R12: A fill replaces whatever line occupied its index, so a later load to the displaced line misses again.
- R13: A load whose index equals the index of the line being installed in the current cycle is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request offered |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_accept | output | 1 | Request taken this cycle |
| rsp_valid | output | 1 | Response word present this cycle |
| rsp_data | output | DATA_W | Response word |
| mreq_full | input | 1 | Memory request queue cannot take an entry |
| mreq_push | output | 1 | Push an entry to the memory request queue |
| mreq_store | output | 1 | 1 = word write, 0 = line read |
| mreq_addr | output | ADDR_W | Word address (line aligned for reads) |
| mreq_wdata | output | DATA_W | Word written |
| mrsp_empty | input | 1 | Memory response queue has no line |
| mrsp_line | input | DATA_W*LINE_WORDS | Line at the head of the memory response queue |
| mrsp_pop | output | 1 | Take the head line |

## Verification
The bench offers load hits on a line already present and load misses to cold lines. A hit is told apart from a miss by whether a line read is pushed and whether a word appears one cycle later. Store hits and store misses are each followed by a load to the same word, which separates updating in place from not allocating. Memory back-pressure and held memory responses fill the miss queue. Against that, hits under misses, refused stores and a refused third miss are checked, and hits offered back to back with waiting lines show that fills yield and still complete in order. A displaced line, a load that collides with a fill in progress and a second instance in blocking mode cover the remaining refusal rules.

// File: rtl/wtc_pkg.sv
// Shared types of the write-through cache controller.
package wtc_pkg;
    // Which source the response phase serves in a given cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HIT  = 2'd1,
        SRC_MISS = 2'd2,
        SRC_FILL = 2'd3
    } rsp_src_e;
endpackage

// File: rtl/wtc_fifo.sv
// Small in-order queue of miss entries.
// Assumes the caller never pushes when full or pops when empty;
// a push and a pop in the same cycle are both honoured.
module wtc_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     slot_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = slot_q[rd_q];

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    // Entry storage, no reset needed.
    always_ff @(posedge clk) begin
        if (do_push) slot_q[wr_q] <= din;
    end
endmodule

// File: rtl/wtc_tagstore.sv
// Direct-mapped tag, valid and data arrays.
// One combinational lookup port, one word read port, one word write
// port and one line fill port. Assumes word write and fill never
// occur in the same cycle; the fill wins if they do.
module wtc_tagstore #(
    parameter int IDX_W      = 3,
    parameter int TAG_W      = 11,
    parameter int OFF_W      = 2,
    parameter int DATA_W     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IDX_W-1:0]              lk_idx,
    input  logic [TAG_W-1:0]              lk_tag,
    output logic                          lk_hit,
    input  logic [IDX_W-1:0]              rd_idx,
    input  logic [OFF_W-1:0]              rd_off,
    output logic [DATA_W-1:0]             rd_word,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [OFF_W-1:0]              wr_off,
    input  logic [DATA_W-1:0]             wr_word,
    input  logic                          fill_en,
    input  logic [IDX_W-1:0]              fill_idx,
    input  logic [TAG_W-1:0]              fill_tag,
    input  logic [DATA_W*(1<<OFF_W)-1:0]  fill_line
);
    localparam int LINES = 1 << IDX_W;
    localparam int WORDS = 1 << OFF_W;

    logic [LINES-1:0]  vld_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES][WORDS];

    assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign rd_word = data_q[rd_idx][rd_off];

    // Valid bits: cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n)       vld_q <= '0;
        else if (fill_en) vld_q[fill_idx] <= 1'b1;
    end

    // Tag and data arrays: whole-line fill or single-word update.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx] <= fill_tag;
            for (int w = 0; w < WORDS; w++) begin
                data_q[fill_idx][w] <= fill_line[w*DATA_W +: DATA_W];
            end
        end else if (wr_en) begin
            data_q[wr_idx][wr_off] <= wr_word;
        end
    end
endmodule

// File: rtl/wt_dcache.sv
// Non-blocking write-through direct-mapped data cache controller.
// Request phase: tag lookup and accept decision in the offered cycle;
// memory pushes and miss-queue pushes happen in the accept cycle.
// Response phase: one cycle later, serves hit slot, then miss slot,
// then a returned line. Assumes the memory answers line reads in order
// and the processor consumes every response cycle.
module wt_dcache
    import wtc_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int LINE_WORDS  = 4,
    parameter int LINES       = 8,
    parameter int MISSQ_DEPTH = 2,
    parameter bit BLOCKING    = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_store,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic                         req_accept,
    output logic                         rsp_valid,
    output logic [DATA_W-1:0]            rsp_data,
    input  logic                         mreq_full,
    output logic                         mreq_push,
    output logic                         mreq_store,
    output logic [ADDR_W-1:0]            mreq_addr,
    output logic [DATA_W-1:0]            mreq_wdata,
    input  logic                         mrsp_empty,
    input  logic [DATA_W*LINE_WORDS-1:0] mrsp_line,
    output logic                         mrsp_pop
);
    localparam int OFF_W = $clog2(LINE_WORDS);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [OFF_W-1:0]  req_off, head_off, hit_off_q;
    logic [IDX_W-1:0]  req_idx, head_idx, hit_idx_q;
    logic [TAG_W-1:0]  req_tag, head_tag;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] hit_wd_q, rd_word;
    logic              hit_v_q, hit_st_q, miss_v_q;
    logic              lk_hit, missq_empty, missq_full;
    logic              take_hit, take_miss, take_store;
    logic              fill_now, collide;
    rsp_src_e          src;

    assign req_off  = req_addr[OFF_W-1:0];
    assign req_idx  = req_addr[OFF_W +: IDX_W];
    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign head_off = head_addr[OFF_W-1:0];
    assign head_idx = head_addr[OFF_W +: IDX_W];
    assign head_tag = head_addr[ADDR_W-1 -: TAG_W];

    // Response source selection in fixed priority.
    always_comb begin
        if (hit_v_q)                          src = SRC_HIT;
        else if (miss_v_q)                    src = SRC_MISS;
        else if (!mrsp_empty && !missq_empty) src = SRC_FILL;
        else                                  src = SRC_NONE;
    end

    assign fill_now = (src == SRC_FILL);
    assign collide  = fill_now && (head_idx == req_idx);

    // Accept decision for the offered request.
    always_comb begin
        req_accept = 1'b0;
        if (req_valid && !(BLOCKING && !missq_empty)) begin
            if (req_store)    req_accept = !mreq_full && missq_empty;
            else if (collide) req_accept = 1'b0;
            else if (lk_hit)  req_accept = 1'b1;
            else              req_accept = !mreq_full && !missq_full;
        end
    end

    assign take_store = req_valid && req_accept && req_store;
    assign take_hit   = req_valid && req_accept && lk_hit;
    assign take_miss  = req_valid && req_accept && !req_store && !lk_hit;

    // Memory request: word write for stores, line read for load misses.
    assign mreq_push  = take_store || take_miss;
    assign mreq_store = req_store;
    assign mreq_addr  = req_store ? req_addr : {req_tag, req_idx, {OFF_W{1'b0}}};
    assign mreq_wdata = req_wdata;
    assign mrsp_pop   = fill_now;

    // One-cycle hit and miss slots handed to the response phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_v_q   <= 1'b0;
            miss_v_q  <= 1'b0;
            hit_st_q  <= 1'b0;
            hit_idx_q <= '0;
            hit_off_q <= '0;
            hit_wd_q  <= '0;
        end else begin
            hit_v_q  <= take_hit;
            miss_v_q <= take_miss;
            if (take_hit) begin
                hit_st_q  <= req_store;
                hit_idx_q <= req_idx;
                hit_off_q <= req_off;
                hit_wd_q  <= req_wdata;
            end
        end
    end

    // Response word: cached word for a load hit, saved offset for a fill.
    assign rsp_valid = ((src == SRC_HIT) && !hit_st_q) || fill_now;
    assign rsp_data  = fill_now ? mrsp_line[int'(head_off)*DATA_W +: DATA_W] : rd_word;

    wtc_fifo #(.W(ADDR_W), .DEPTH(MISSQ_DEPTH)) u_missq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (take_miss),
        .din   (req_addr),
        .pop   (fill_now),
        .dout  (head_addr),
        .empty (missq_empty),
        .full  (missq_full)
    );

    wtc_tagstore #(.IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (req_idx),
        .lk_tag    (req_tag),
        .lk_hit    (lk_hit),
        .rd_idx    (hit_idx_q),
        .rd_off    (hit_off_q),
        .rd_word   (rd_word),
        .wr_en     ((src == SRC_HIT) && hit_st_q),
        .wr_idx    (hit_idx_q),
        .wr_off    (hit_off_q),
        .wr_word   (hit_wd_q),
        .fill_en   (fill_now),
        .fill_idx  (head_idx),
        .fill_tag  (head_tag),
        .fill_line (mrsp_line)
    );
endmodule

// File: rtl/wt_dcache_chk.sv
// Protocol and ordering checks for wt_dcache, attached by bind.
module wt_dcache_chk #(
    parameter bit BLOCKING = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_store,
    input logic req_accept,
    input logic lk_hit,
    input logic rsp_valid,
    input logic mreq_full,
    input logic mreq_push,
    input logic mreq_store,
    input logic mrsp_empty,
    input logic mrsp_pop,
    input logic hit_v_q,
    input logic miss_v_q,
    input logic missq_empty
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rsp_valid && !mrsp_pop));

    p_hit_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_accept && !req_store && lk_hit) |=> rsp_valid);

    p_miss_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_accept && !req_store && !lk_hit) |=> (!rsp_valid && !mrsp_pop));

    p_pop_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mrsp_pop |-> (!mrsp_empty && !missq_empty && rsp_valid));

    p_fill_yield_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_v_q || miss_v_q) |-> !mrsp_pop);

    p_push_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_push |-> !mreq_full);

    p_store_through_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_accept && req_store) |-> (mreq_push && mreq_store));

    p_store_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_accept && req_store) |=> !rsp_valid);

    p_store_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && !missq_empty) |-> !req_accept);

    p_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (BLOCKING && req_valid && !missq_empty) |-> !req_accept);
endmodule

bind wt_dcache wt_dcache_chk #(.BLOCKING(BLOCKING)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_store   (req_store),
    .req_accept  (req_accept),
    .lk_hit      (lk_hit),
    .rsp_valid   (rsp_valid),
    .mreq_full   (mreq_full),
    .mreq_push   (mreq_push),
    .mreq_store  (mreq_store),
    .mrsp_empty  (mrsp_empty),
    .mrsp_pop    (mrsp_pop),
    .hit_v_q     (hit_v_q),
    .miss_v_q    (miss_v_q),
    .missq_empty (missq_empty)
);

// File: tb/sim_wt_dcache.sv
// Scoreboard bench for wt_dcache: u0 non-blocking with a memory model,
// u1 blocking with a memory that never answers.
module sim_wt_dcache;
    localparam int CLK_P = 10;
    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int LW    = DW * 4;
    localparam int LAT   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_store = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_accept, rsp_valid, mreq_push, mreq_store, mrsp_pop;
    logic [DW-1:0] rsp_data, mreq_wdata;
    logic [AW-1:0] mreq_addr;
    logic          mreq_full = 1'b0, mrsp_empty = 1'b1;
    logic [LW-1:0] mrsp_line = '0;

    logic          b_valid = 1'b0, b_store = 1'b0;
    logic [AW-1:0] b_addr = '0;
    logic          b_accept, b_rsp_valid, b_mpush, b_mstore, b_mpop;
    logic [DW-1:0] b_rsp_data, b_mwdata;
    logic [AW-1:0] b_maddr;

    int            checks = 0, failures = 0, cyc = 0;
    logic          mfull = 1'b0, hold = 1'b0;
    logic [DW-1:0] wmem [logic [AW-1:0]];
    logic [LW-1:0] lineq [$];
    int            readyq [$];
    logic [DW-1:0] expq [$];
    logic          s_acc, s_push, s_mst, s_rv, s_pop, s_bacc;
    logic [AW-1:0] s_maddr;
    logic [DW-1:0] s_rd, s_mwd, got;

    always #(CLK_P/2) clk = ~clk;

    wt_dcache u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_accept(req_accept),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mreq_full(mreq_full),
        .mreq_push(mreq_push), .mreq_store(mreq_store), .mreq_addr(mreq_addr),
        .mreq_wdata(mreq_wdata), .mrsp_empty(mrsp_empty), .mrsp_line(mrsp_line),
        .mrsp_pop(mrsp_pop));

    wt_dcache #(.BLOCKING(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_store(b_store),
        .req_addr(b_addr), .req_wdata(32'h0), .req_accept(b_accept),
        .rsp_valid(b_rsp_valid), .rsp_data(b_rsp_data), .mreq_full(1'b0),
        .mreq_push(b_mpush), .mreq_store(b_mstore), .mreq_addr(b_maddr),
        .mreq_wdata(b_mwdata), .mrsp_empty(1'b1), .mrsp_line({LW{1'b0}}),
        .mrsp_pop(b_mpop));

    function automatic logic [DW-1:0] memword(input logic [AW-1:0] a);
        if (wmem.exists(a)) return wmem[a];
        return {16'hC0DE, a};
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive memory side, sample mid-cycle, update model and scoreboard.
    task automatic step();
        logic [LW-1:0] ln;
        int            hit_at;
        mreq_full  = mfull;
        mrsp_empty = !(lineq.size() > 0 && !hold && readyq[0] <= cyc);
        mrsp_line  = (lineq.size() > 0) ? lineq[0] : '0;
        #(CLK_P/4);
        s_acc = req_accept; s_push = mreq_push; s_mst = mreq_store;
        s_maddr = mreq_addr; s_mwd = mreq_wdata; s_rv = rsp_valid;
        s_rd = rsp_data; s_pop = mrsp_pop; s_bacc = b_accept;
        if (req_valid && s_acc && !req_store) expq.push_back(memword(req_addr));
        if (s_rv) begin
            hit_at = -1;
            foreach (expq[i]) if (hit_at < 0 && expq[i] == s_rd) hit_at = i;
            checks++;
            if (hit_at < 0) begin
                failures++;
                $display("FAIL R4 unexpected response actual=%h expected=one of %0d pending", s_rd, expq.size());
            end else expq.delete(hit_at);
        end
        if (s_pop && lineq.size() > 0) begin
            void'(lineq.pop_front());
            void'(readyq.pop_front());
        end
        if (s_push) begin
            if (s_mst) wmem[s_maddr] = s_mwd;
            else begin
                for (int w = 0; w < 4; w++) ln[w*DW +: DW] = memword({s_maddr[AW-1:2], 2'(w)});
                lineq.push_back(ln);
                readyq.push_back(cyc + LAT);
            end
        end
        @(posedge clk);
        cyc++;
        @(negedge clk);
    endtask

    task automatic req(input logic st, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_store = st; req_addr = a; req_wdata = d;
        step();
        req_valid = 1'b0;
    endtask

    task automatic idle();
        req_valid = 1'b0;
        step();
    endtask

    task automatic wait_rsp(input string tag, output logic [DW-1:0] d);
        d = '0;
        for (int i = 0; i < 20; i++) begin
            idle();
            if (s_rv) begin d = s_rd; return; end
        end
        checks++; failures++;
        $display("FAIL %s no response actual=none expected=word", tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rsp_valid", 32'(rsp_valid), 32'h0);
        rst_n = 1'b1;
        idle();
        check("R1 idle rsp_valid", 32'(s_rv), 0);
        check("R1 idle mreq_push", 32'(s_push), 0);
        check("R1 idle mrsp_pop", 32'(s_pop), 0);

        // Cold load: miss, line read, silent next cycle, fill with saved offset.
        req(1'b0, 16'h0041, '0);
        check("R1 cold load accepted", 32'(s_acc), 1);
        check("R3 miss pushes line read", {s_push, s_mst}, 32'b10);
        check("R3 line aligned address", 32'(s_maddr), 32'h0040);
        idle();
        check("R3 no response after miss", 32'(s_rv), 0);
        wait_rsp("R4 fill", got);
        check("R4 fill word at saved offset", got, 32'hC0DE0041);

        // Load hit.
        req(1'b0, 16'h0043, '0);
        check("R2 hit accepted", 32'(s_acc), 1);
        check("R2 hit no memory push", 32'(s_push), 0);
        idle();
        check("R2 hit answered next cycle", 32'(s_rv), 1);
        check("R2 hit word", s_rd, 32'hC0DE0043);

        // Store hit: write-through and update in place.
        req(1'b1, 16'h0042, 32'h11112222);
        check("R6 store accepted", 32'(s_acc), 1);
        check("R6 store pushes word write", {s_push, s_mst}, 32'b11);
        check("R6 store address", 32'(s_maddr), 32'h0042);
        check("R6 store data", s_mwd, 32'h11112222);
        req(1'b0, 16'h0042, '0);
        check("R6 store gives no response", 32'(s_rv), 0);
        check("R7 load after store hit is a hit", 32'(s_push), 0);
        idle();
        check("R7 updated word", s_rd, 32'h11112222);

        // Store miss: no allocate.
        req(1'b1, 16'h0105, 32'h33334444);
        check("R6 store miss written through", {s_push, s_mst}, 32'b11);
        req(1'b0, 16'h0105, '0);
        check("R8 load after store miss misses", {s_push, s_mst}, 32'b10);
        check("R8 line read address", 32'(s_maddr), 32'h0104);
        wait_rsp("R8 fill", got);
        check("R8 fill returns written word", got, 32'h33334444);

        // Memory back-pressure.
        mfull = 1'b1;
        req(1'b1, 16'h0042, 32'h55556666);
        check("R6 store refused when full", {s_acc, s_push}, 32'b00);
        req(1'b0, 16'h0200, '0);
        check("R3 miss refused when full", {s_acc, s_push}, 32'b00);
        req(1'b0, 16'h0041, '0);
        check("R2 hit accepted when full", 32'(s_acc), 1);
        mfull = 1'b0;
        idle();
        check("R2 hit word under full", s_rd, 32'hC0DE0041);

        // Fill the miss queue with responses held back.
        hold = 1'b1;
        req(1'b0, 16'h0088, '0);
        check("R3 first miss accepted", 32'(s_acc), 1);
        req(1'b0, 16'h00AC, '0);
        check("R3 second miss accepted", 32'(s_acc), 1);
        req(1'b0, 16'h00C0, '0);
        check("R3 miss refused when queue full", {s_acc, s_push}, 32'b00);
        req(1'b1, 16'h0043, 32'h77778888);
        check("R9 store refused with misses pending", {s_acc, s_push}, 32'b00);
        req(1'b0, 16'h0041, '0);
        check("R10 hit under miss accepted", 32'(s_acc), 1);
        idle();
        check("R10 hit under miss answered", s_rd, 32'hC0DE0041);
        idle();

        // Priority: hits delay waiting fills; fills stay in order.
        hold = 1'b0;
        req(1'b0, 16'h0041, '0);
        check("R4 oldest fill first", {31'(0), s_pop}, 1);
        check("R4 oldest fill word", s_rd, 32'hC0DE0088);
        req(1'b0, 16'h0043, '0);
        check("R5 fill waits for hit slot", 32'(s_pop), 0);
        check("R5 hit served first", s_rd, 32'hC0DE0041);
        idle();
        check("R5 fill waits for second hit", 32'(s_pop), 0);
        idle();
        check("R4 second fill popped", 32'(s_pop), 1);
        check("R4 second fill word", s_rd, 32'hC0DE00AC);

        // Displacement at a shared index.
        req(1'b0, 16'h0200, '0);
        wait_rsp("R12 fill", got);
        req(1'b0, 16'h0041, '0);
        check("R12 displaced line misses", {s_push, s_mst}, 32'b10);
        check("R12 line read address", 32'(s_maddr), 32'h0040);
        wait_rsp("R12 refill", got);
        check("R12 refill word", got, 32'hC0DE0041);

        // Load colliding with a fill in progress.
        hold = 1'b1;
        req(1'b0, 16'h0061, '0);
        repeat (4) idle();
        hold = 1'b0;
        req(1'b0, 16'h0042, '0);
        check("R13 colliding load refused", 32'(s_acc), 0);
        check("R13 fill proceeds", 32'(s_pop), 1);
        req(1'b0, 16'h0042, '0);
        check("R13 retried load now misses", {s_acc, s_push}, 32'b11);
        wait_rsp("R13 fill", got);
        check("R13 retried load word", got, 32'h11112222);

        // Blocking instance.
        b_valid = 1'b1; b_addr = 16'h0010;
        idle();
        check("R11 first miss accepted", 32'(s_bacc), 1);
        b_addr = 16'h0020;
        idle();
        check("R11 load refused while miss pending", 32'(s_bacc), 0);
        b_store = 1'b1;
        idle();
        check("R11 store refused while miss pending", 32'(s_bacc), 0);
        b_valid = 1'b0; b_store = 1'b0;

        repeat (3) idle();
        check("R4 every load answered", 32'(expq.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule